// File: doc/BRIEF.md
# Power-Save Wakeup Cause Controller

This block sits beside a processor thread's exception logic and owns its low-power state. A power-save request from the instruction pipeline names one of four depth codes. The block then halts the thread, forces the external-interrupt enable on and watches seven pending interrupt lines. Five qualifier bits in a partition control field decide which of those lines may end the halt. A pending system reset ends it in every case.

When a qualified source is seen, the block releases the halt and, for exactly one cycle, presents a registered wake report. The report holds a vector-redirect flag, a 4-bit cause code and a 64-bit saved-status contribution word. The exception unit merges that word into its saved machine status and, when the flag is set, fetches from the reset vector. A machine-check wakeup keeps its own vector and carries no cause. The depth code is kept for the platform while the thread is halted. The saved-status word always reports the lightest depth, because this model loses no state.

Top module: `pwrsave_wake_ctrl`

## Requirements
- R1: After a synchronous reset, `halted`, `ee_force`, `wake_pulse`, `wake_to_reset`, `wake_cause` and `wake_status` are all 0, and `wake_en` is 5'b11111.
- R2: While running, a `ps_req` cycle with any depth code (0 doze, 1 nap, 2 sleep, 3 deepest) sets `halted` and `ee_force` after the next clock edge, and `hold_depth` shows the requested code.
- R3: While halted, an external request (`pend[3]`) wakes the thread only when `wake_en[2]` is 1. A decrementer request (`pend[4]`) wakes it only when `wake_en[3]` is 1.
- R4: Machine check (`pend[1]`) and hypervisor maintenance (`pend[2]`) each wake the thread only when `wake_en[4]` is 1.
- R5: A hypervisor doorbell (`pend[5]`) needs `wake_en[1]`, and a privileged doorbell (`pend[6]`) needs `wake_en[0]`.
- R6: A pending system reset (`pend[0]`) wakes a halted thread whatever the value of `wake_en`.
- R7: One clock edge after a qualified source is seen while halted, `wake_pulse` is 1, `halted` is 0, and `wake_status` bit 16 (bit 47 counted from the MSB of 64) is 1, which reports the doze depth.
- R8: For a non-machine-check wakeup, `wake_to_reset` is 1, and `wake_cause` and `wake_status[21:18]` (bits 42..45 counted from the MSB) carry: reset 0x4, external 0x8, decrementer 0x6, privileged doorbell 0x5, hypervisor doorbell 0x3, hypervisor maintenance 0xA.
- R9: For a machine-check wakeup, `wake_to_reset` is 0, `wake_cause` is 0, and `wake_status` has only bit 16 set.
- R10: When several qualified sources are pending in the same cycle, the lowest `pend` index wins. The order is reset, machine check, hypervisor maintenance, external, decrementer, hypervisor doorbell, privileged doorbell.
- R11: The wake report lasts exactly one cycle. On the next cycle all wake outputs are 0, the block is running again and `ee_force` is 0.
- R12: While running, pending lines have no effect: `wake_pulse` and `halted` stay 0.
- R13: A cycle with `en_wr` high loads `en_wdata` into `wake_en`, and the new value is visible after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ps_req | input | 1 | Power-save entry request, one cycle |
| ps_depth | input | 2 | Requested depth code |
| pend | input | 7 | Pending interrupt lines, index order as in R10 |
| en_wr | input | 1 | Write strobe for the wake-enable field |
| en_wdata | input | 5 | New wake-enable value |
| wake_en | output | 5 | Current wake-enable field |
| halted | output | 1 | Thread is held in power save |
| hold_depth | output | 2 | Depth code of the current halt |
| ee_force | output | 1 | External-interrupt enable forced on |
| wake_pulse | output | 1 | One-cycle wake report strobe |
| wake_to_reset | output | 1 | Redirect the wakeup to the reset vector |
| wake_cause | output | 4 | Encoded wakeup cause |
| wake_status | output | 64 | Saved-status contribution word |

## Verification
Each failure mode has its own signature at the ports. A wrong gate mapping shows up as a missing or spurious `wake_pulse` exactly one edge after a single source is raised while halted. A wrong priority or cause table shows up as a wrong `wake_cause` or `wake_status` in that same pulse cycle. A state machine that fails to return to running is caught one cycle later, because `halted`, `ee_force` or `wake_pulse` keeps a stale value. A block that wakes while running is caught as soon as pending lines are driven with no request outstanding.

// File: rtl/pwrsave_pkg.sv
package pwrsave_pkg;

    localparam int NUM_SRC   = 7;
    localparam int NUM_EN    = 5;
    localparam int STAT_W    = 64;
    localparam int CAUSE_W   = 4;
    localparam int LOSS_POS  = STAT_W - 1 - 47;
    localparam int CAUSE_LSB = STAT_W - 1 - 45;

    // source index doubles as priority: lower index wins
    localparam int SRC_RST = 0;
    localparam int SRC_MCK = 1;
    localparam int SRC_HMI = 2;
    localparam int SRC_EXT = 3;
    localparam int SRC_DEC = 4;
    localparam int SRC_HDB = 5;
    localparam int SRC_PDB = 6;

    typedef enum logic [1:0] {
        DEPTH_DOZE   = 2'd0,
        DEPTH_NAP    = 2'd1,
        DEPTH_SLEEP  = 2'd2,
        DEPTH_WINKLE = 2'd3
    } depth_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_WAKE = 2'd2
    } pstate_e;

    typedef struct packed {
        logic               to_reset;
        logic [CAUSE_W-1:0] cause;
    } wake_info_t;

    // which enable bit qualifies a source; -1 means never gated
    function automatic int gate_bit(int src);
        case (src)
            SRC_MCK: return 4;
            SRC_HMI: return 4;
            SRC_EXT: return 2;
            SRC_DEC: return 3;
            SRC_HDB: return 1;
            SRC_PDB: return 0;
            default: return -1;
        endcase
    endfunction

    function automatic logic [CAUSE_W-1:0] cause_code(int src);
        case (src)
            SRC_RST: return 4'h4;
            SRC_HMI: return 4'hA;
            SRC_EXT: return 4'h8;
            SRC_DEC: return 4'h6;
            SRC_HDB: return 4'h3;
            SRC_PDB: return 4'h5;
            default: return 4'h0;
        endcase
    endfunction

endpackage

// File: rtl/pwrsave_qual.sv
module pwrsave_qual
    import pwrsave_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int NEN  = NUM_EN
) (
    input  logic [NSRC-1:0] pend,
    input  logic [NEN-1:0]  en,
    output logic [NSRC-1:0] sel,
    output logic            any
);
    logic [NSRC-1:0] qual;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        localparam int GB = gate_bit(g);
        if (GB < 0) begin : g_always
            assign qual[g] = pend[g];
        end else begin : g_gated
            assign qual[g] = pend[g] & en[GB];
        end
    end

    // isolate lowest set bit: fixed priority by index
    assign sel = qual & (~qual + NSRC'(1));
    assign any = |qual;

    always_comb begin
        p_sel_onehot_r10: assert ($onehot0(sel));
        p_sel_when_any_r10: assert (any == (sel != '0));
    end
endmodule

// File: rtl/pwrsave_fsm.sv
module pwrsave_fsm
    import pwrsave_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ps_req,
    input  logic [1:0] ps_depth,
    input  logic       any_wake,
    output logic       halted,
    output logic       ee_force,
    output logic [1:0] hold_depth,
    output logic       wake_fire
);
    pstate_e state, state_n;
    depth_e  depth_q;

    always_comb begin
        state_n = state;
        case (state)
            ST_RUN:  if (ps_req)   state_n = ST_HALT;
            ST_HALT: if (any_wake) state_n = ST_WAKE;
            ST_WAKE: state_n = ST_RUN;
            default: state_n = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_RUN;
            depth_q <= DEPTH_DOZE;
        end else begin
            state <= state_n;
            if (state == ST_RUN && ps_req)
                depth_q <= depth_e'(ps_depth);
        end
    end

    assign halted     = (state == ST_HALT);
    assign ee_force   = (state != ST_RUN);
    assign hold_depth = depth_q;
    assign wake_fire  = (state == ST_HALT) && any_wake;

    p_enter_halt_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && ps_req) |=> halted);
    p_depth_kept_r2: assert property (@(posedge clk) disable iff (rst)
        (halted && $past(halted)) |-> $stable(hold_depth));
    p_wake_returns_r11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE) |=> (state == ST_RUN));
endmodule

// File: rtl/pwrsave_wake_out.sv
module pwrsave_wake_out
    import pwrsave_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int SW   = STAT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic [NSRC-1:0]    sel,
    output logic               wake_pulse,
    output logic               wake_to_reset,
    output logic [CAUSE_W-1:0] wake_cause,
    output logic [SW-1:0]      wake_status
);
    wake_info_t     info;
    logic [SW-1:0]  stat_n;

    always_comb begin
        info.cause    = '0;
        for (int i = 0; i < NSRC; i++)
            if (sel[i]) info.cause |= cause_code(i);
        info.to_reset = (|sel) & ~sel[SRC_MCK];
        stat_n        = '0;
        stat_n[LOSS_POS] = 1'b1;
        stat_n[CAUSE_LSB +: CAUSE_W] = info.cause;
    end

    always_ff @(posedge clk) begin
        if (rst || !fire) begin
            wake_pulse    <= 1'b0;
            wake_to_reset <= 1'b0;
            wake_cause    <= '0;
            wake_status   <= '0;
        end else begin
            wake_pulse    <= 1'b1;
            wake_to_reset <= info.to_reset;
            wake_cause    <= info.cause;
            wake_status   <= stat_n;
        end
    end

    p_pulse_single_r11: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);
    p_loss_bit_r7: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> wake_status[LOSS_POS]);
    p_mck_no_cause_r9: assert property (@(posedge clk) disable iff (rst)
        (wake_pulse && !wake_to_reset) |-> (wake_cause == '0));
    p_cause_in_status_r8: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> (wake_status[CAUSE_LSB +: CAUSE_W] == wake_cause));
endmodule

// File: rtl/pwrsave_wake_ctrl.sv
module pwrsave_wake_ctrl
    import pwrsave_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int NEN  = NUM_EN,
    parameter int SW   = STAT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ps_req,
    input  logic [1:0]         ps_depth,
    input  logic [NSRC-1:0]    pend,
    input  logic               en_wr,
    input  logic [NEN-1:0]     en_wdata,
    output logic [NEN-1:0]     wake_en,
    output logic               halted,
    output logic [1:0]         hold_depth,
    output logic               ee_force,
    output logic               wake_pulse,
    output logic               wake_to_reset,
    output logic [CAUSE_W-1:0] wake_cause,
    output logic [SW-1:0]      wake_status
);
    localparam logic [NEN-1:0] EN_RESET = '1;

    logic [NSRC-1:0] sel;
    logic            any_wake;
    logic            wake_fire;

    always_ff @(posedge clk) begin
        if (rst)        wake_en <= EN_RESET;
        else if (en_wr) wake_en <= en_wdata;
    end

    pwrsave_qual #(.NSRC(NSRC), .NEN(NEN)) qual_i (
        .pend (pend),
        .en   (wake_en),
        .sel  (sel),
        .any  (any_wake)
    );

    pwrsave_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .ps_req     (ps_req),
        .ps_depth   (ps_depth),
        .any_wake   (any_wake),
        .halted     (halted),
        .ee_force   (ee_force),
        .hold_depth (hold_depth),
        .wake_fire  (wake_fire)
    );

    pwrsave_wake_out #(.NSRC(NSRC), .SW(SW)) out_i (
        .clk           (clk),
        .rst           (rst),
        .fire          (wake_fire),
        .sel           (sel),
        .wake_pulse    (wake_pulse),
        .wake_to_reset (wake_to_reset),
        .wake_cause    (wake_cause),
        .wake_status   (wake_status)
    );

    p_reset_wakes_r6: assert property (@(posedge clk) disable iff (rst)
        (halted && pend[SRC_RST]) |=> wake_pulse);
    p_wake_after_halt_r12: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> $past(halted));
    p_wake_releases_r7: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> !halted);
    p_en_write_r13: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> (wake_en == $past(en_wdata)));
endmodule

// File: tb/pwrsave_wake_ctrl_tb.sv
module pwrsave_wake_ctrl_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ps_req = 1'b0;
    logic [1:0]  ps_depth = 2'd0;
    logic [6:0]  pend = '0;
    logic        en_wr = 1'b0;
    logic [4:0]  en_wdata = '0;
    logic [4:0]  wake_en;
    logic        halted;
    logic [1:0]  hold_depth;
    logic        ee_force;
    logic        wake_pulse;
    logic        wake_to_reset;
    logic [3:0]  wake_cause;
    logic [63:0] wake_status;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pwrsave_wake_ctrl dut_i (
        .clk(clk), .rst(rst), .ps_req(ps_req), .ps_depth(ps_depth),
        .pend(pend), .en_wr(en_wr), .en_wdata(en_wdata), .wake_en(wake_en),
        .halted(halted), .hold_depth(hold_depth), .ee_force(ee_force),
        .wake_pulse(wake_pulse), .wake_to_reset(wake_to_reset),
        .wake_cause(wake_cause), .wake_status(wake_status)
    );

    // {req tag, en[4:0], pend[6:0], wake, to_reset, cause[3:0]}
    localparam int NV = 20;
    localparam logic [21:0] VEC [NV] = '{
        {4'd3,  5'h1F, 7'h08, 1'b1, 1'b1, 4'h8},  // R3 external enabled
        {4'd3,  5'h1B, 7'h08, 1'b0, 1'b0, 4'h0},  // R3 external gated
        {4'd3,  5'h1F, 7'h10, 1'b1, 1'b1, 4'h6},  // R3 decrementer
        {4'd3,  5'h17, 7'h10, 1'b0, 1'b0, 4'h0},  // R3 decrementer gated
        {4'd4,  5'h1F, 7'h04, 1'b1, 1'b1, 4'hA},  // R4 maintenance
        {4'd4,  5'h0F, 7'h04, 1'b0, 1'b0, 4'h0},  // R4 maintenance gated
        {4'd9,  5'h1F, 7'h02, 1'b1, 1'b0, 4'h0},  // R9 machine check
        {4'd4,  5'h0F, 7'h02, 1'b0, 1'b0, 4'h0},  // R4 machine check gated
        {4'd5,  5'h1F, 7'h40, 1'b1, 1'b1, 4'h5},  // R5 privileged doorbell
        {4'd5,  5'h1E, 7'h40, 1'b0, 1'b0, 4'h0},  // R5 gated
        {4'd5,  5'h1F, 7'h20, 1'b1, 1'b1, 4'h3},  // R5 hypervisor doorbell
        {4'd5,  5'h1D, 7'h20, 1'b0, 1'b0, 4'h0},  // R5 gated
        {4'd6,  5'h00, 7'h01, 1'b1, 1'b1, 4'h4},  // R6 reset, no enables
        {4'd10, 5'h1F, 7'h7F, 1'b1, 1'b1, 4'h4},  // R10 all pending
        {4'd10, 5'h1F, 7'h7E, 1'b1, 1'b0, 4'h0},  // R10 mck wins
        {4'd10, 5'h1F, 7'h7C, 1'b1, 1'b1, 4'hA},  // R10 maint wins
        {4'd10, 5'h1F, 7'h78, 1'b1, 1'b1, 4'h8},  // R10 external wins
        {4'd10, 5'h1F, 7'h70, 1'b1, 1'b1, 4'h6},  // R10 decrementer wins
        {4'd10, 5'h1F, 7'h60, 1'b1, 1'b1, 4'h3},  // R10 hv doorbell wins
        {4'd10, 5'h0F, 7'h7E, 1'b1, 1'b1, 4'h8}   // R10 gated top skipped
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] stat_of(input logic [3:0] c);
        return (64'd1 << 16) | (64'(c) << 18);
    endfunction

    task automatic enter(input logic [1:0] d);
        ps_req = 1'b1; ps_depth = d;
        tick();
        ps_req = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "halted", 64'(halted), 64'd0);
        chk("R1", "ee_force", 64'(ee_force), 64'd0);
        chk("R1", "wake_pulse", 64'(wake_pulse), 64'd0);
        chk("R1", "wake_cause", 64'(wake_cause), 64'd0);
        chk("R1", "wake_status", wake_status, 64'd0);
        chk("R1", "wake_en", 64'(wake_en), 64'h1F);

        // R12 pending lines while running
        pend = 7'h7F;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R12", "wake_pulse", 64'(wake_pulse), 64'd0);
            chk("R12", "halted", 64'(halted), 64'd0);
        end
        pend = '0;

        // R13 enable write
        en_wr = 1'b1; en_wdata = 5'h0A;
        tick();
        en_wr = 1'b0;
        chk("R13", "wake_en", 64'(wake_en), 64'h0A);

        for (int i = 0; i < NV; i++) begin
            logic [3:0] rq;
            logic [4:0] ev;
            logic [6:0] pv;
            logic       ew, er;
            logic [3:0] ec;
            string      tag;
            {rq, ev, pv, ew, er, ec} = VEC[i];
            tag = $sformatf("R%0d", rq);
            en_wr = 1'b1; en_wdata = ev;
            tick();
            en_wr = 1'b0;
            enter(2'(i % 4));
            // R2 entry with each depth code
            chk("R2", "halted", 64'(halted), 64'd1);
            chk("R2", "ee_force", 64'(ee_force), 64'd1);
            chk("R2", "hold_depth", 64'(hold_depth), 64'(i % 4));
            pend = pv;
            tick();
            if (ew) begin
                chk(tag, "wake_pulse", 64'(wake_pulse), 64'd1);
                chk("R7", "halted", 64'(halted), 64'd0);
                chk(tag, "to_reset", 64'(wake_to_reset), 64'(er));
                chk(tag, "cause", 64'(wake_cause), 64'(ec));
                chk("R8", "status", wake_status, stat_of(ec));
            end else begin
                chk(tag, "no wake", 64'(wake_pulse), 64'd0);
                chk(tag, "still halted", 64'(halted), 64'd1);
                pend = 7'h01;
                tick();
                chk("R6", "reset wake", 64'(wake_pulse), 64'd1);
                chk("R6", "reset cause", 64'(wake_cause), 64'h4);
            end
            pend = '0;
            tick();
            // R11 report lasts one cycle
            chk("R11", "pulse end", 64'(wake_pulse), 64'd0);
            chk("R11", "status clr", wake_status, 64'd0);
            chk("R11", "ee_force", 64'(ee_force), 64'd0);
            chk("R11", "running", 64'(halted), 64'd0);
        end

        // R7 loss bit reported as doze after deepest request
        enter(2'd3);
        pend = 7'h01;
        tick();
        pend = '0;
        chk("R7", "loss bit", 64'(wake_status[16]), 64'd1);
        tick();

        // R1 reset in the middle of a halt
        enter(2'd2);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1", "halt cleared", 64'(halted), 64'd0);
        chk("R1", "en restored", 64'(wake_en), 64'h1F);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule